// File: doc/BRIEF.md
# Cache-Line Crossing Access Splitter

This block sits between a load/store source and a cache port. It accepts one memory request at a time, carrying a start address, a byte count, a read/write flag, store data and a group of pass-through flag bits. It then decides whether the bytes touched fall into one cache line or two. The line size is a power-of-two parameter. To find the boundary, the block takes the address of the last byte touched and masks off its low offset bits. If that boundary lies above the start address, the request spans two lines.

A request that stays inside one line goes downstream unchanged as a single access. A spanning request is sent as two accesses, one after the other. The low part runs from the start address up to the boundary. The high part starts at the boundary and carries the remaining bytes. Store data is sliced so that each part presents its own bytes in the low lanes. For loads, the bytes returned by each part are merged into one result buffer at the correct offset. A counter of part responses decides when the whole request is finished. A one-cycle completion pulse then presents the merged data.

The downstream side is a valid/ready request channel plus a response strobe with read data. The block accepts a new request in the same cycle as it reports the previous one complete, so back-to-back requests lose no cycle at the upstream edge.

Top module: `line_split_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and both mem_valid and done_valid are 0.
- R2: With B = (A + S - 1) with the low log2(LINE_BYTES) bits cleared, a request at address A of S bytes (1 ≤ S ≤ MAX_BYTES) is split exactly when B > A. Otherwise it is sent as one access with address A and size S.
- R3: The first part of a split request carries address A and size B - A. No downstream access ever covers bytes of two different lines.
- R4: The second part carries address B and size A + S - B. It is raised on mem_valid only after the first part's response strobe has been received.
- R5: While mem_valid is 1 and mem_ready is 0, the downstream request is held with the same address and size. Each part is handed over exactly once, so a stalled first part never produces a second copy of the second part.
- R6: Both parts copy the write flag and the flag bits of the request. For stores, the low mem_size bytes of mem_wdata hold request bytes 0 to B-A-1 in the first part and request bytes B-A to S-1 in the second part. Byte k is bits 8k+7:8k.
- R7: For loads, byte k of done_rdata equals byte k of the first part's mem_rdata for k < B-A, and byte k-(B-A) of the second part's mem_rdata for B-A ≤ k < S. Bytes at or above S are 0, and for a non-split load the whole first part applies. For stores, done_rdata is all zero.
- R8: done_valid is a one-cycle pulse in the cycle after the final part's response strobe. The final part is the second for a split request and the only part otherwise. done_split is 1 in that cycle exactly when the request was split.
- R9: req_ready is 0 from the cycle after a request is accepted until completion. It is 1 in the cycle where done_valid is 1, and a request presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SIZE_W | Byte count, 1 to MAX_BYTES |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 8*MAX_BYTES | Store bytes, byte 0 in the low lanes |
| req_flags | input | FLAG_W | Attribute bits copied to every part |
| mem_valid | output | 1 | Downstream part request present |
| mem_ready | input | 1 | Downstream takes the part |
| mem_addr | output | ADDR_W | Part start address |
| mem_size | output | SIZE_W | Part byte count |
| mem_write | output | 1 | Part is a store |
| mem_wdata | output | 8*MAX_BYTES | Part store bytes in the low lanes |
| mem_flags | output | FLAG_W | Copied attribute bits |
| mem_resp | input | 1 | Response strobe for the outstanding part |
| mem_rdata | input | 8*MAX_BYTES | Part load bytes in the low lanes |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8*MAX_BYTES | Merged load bytes |
| done_split | output | 1 | Completed request used two parts |

## Verification
Two functions can fall in the same cycle: reporting one request complete and accepting the next one. The bench starts every new request in the exact cycle where it sees the completion pulse, and it checks there that req_ready is high and that the pulse lands one cycle after the last response strobe. It sweeps every start offset across four lines and every size in both directions, under four mixes of downstream stall and response delay. Each part's address, size and data slice, and the merged result, are judged against values computed arithmetically from the boundary formula.

// File: rtl/line_split_unit.sv
module line_split_unit #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 8,
  parameter int FLAG_W     = 4,
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W    = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [FLAG_W-1:0] req_flags,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SIZE_W-1:0] mem_size,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [FLAG_W-1:0] mem_flags,
  input  logic              mem_resp,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_valid,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_split
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_t;
  st_t st_q;

  logic [ADDR_W-1:0] lo_addr_q, hi_addr_q;
  logic [SIZE_W-1:0] tot_q, lo_size_q;
  logic              wr_q, two_q, done_q;
  logic [1:0]        cnt_q;
  logic [DATA_W-1:0] wd_q, buf_q;
  logic [FLAG_W-1:0] flags_q;

  logic [ADDR_W-1:0] last_byte, bnd;
  logic              crosses;
  assign last_byte = req_addr + ADDR_W'(req_size) - ADDR_W'(1);
  assign bnd       = last_byte & ~OFF_MASK;
  assign crosses   = bnd > req_addr;

  logic              on_hi;
  logic [SIZE_W-1:0] lane_off;
  logic [DATA_W-1:0] rd_shift;
  logic [MAX_BYTES-1:0] lane_en;
  logic              last_part;

  assign on_hi     = cnt_q != 2'd0;
  assign lane_off  = on_hi ? lo_size_q : '0;
  assign mem_valid = st_q == ST_ISSUE;
  assign mem_addr  = on_hi ? hi_addr_q : lo_addr_q;
  assign mem_size  = on_hi ? tot_q - lo_size_q : lo_size_q;
  assign mem_write = wr_q;
  assign mem_flags = flags_q;
  assign mem_wdata = wd_q >> {lane_off, 3'b000};
  assign rd_shift  = mem_rdata << {lane_off, 3'b000};
  assign last_part = (cnt_q + 2'd1) == (two_q ? 2'd2 : 2'd1);

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    assign lane_en[k] = (k >= int'(lane_off)) && (k < int'(lane_off) + int'(mem_size));
  end

  assign req_ready  = st_q == ST_IDLE;
  assign done_valid = done_q;
  assign done_rdata = buf_q;
  assign done_split = two_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      lo_addr_q <= '0;
      hi_addr_q <= '0;
      tot_q     <= '0;
      lo_size_q <= '0;
      wr_q      <= 1'b0;
      two_q     <= 1'b0;
      done_q    <= 1'b0;
      cnt_q     <= '0;
      wd_q      <= '0;
      buf_q     <= '0;
      flags_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          lo_addr_q <= req_addr;
          hi_addr_q <= bnd;
          tot_q     <= req_size;
          lo_size_q <= crosses ? SIZE_W'(bnd - req_addr) : req_size;
          two_q     <= crosses;
          wr_q      <= req_write;
          wd_q      <= req_wdata;
          flags_q   <= req_flags;
          buf_q     <= '0;
          cnt_q     <= '0;
          st_q      <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_resp) begin
          if (!wr_q) begin
            for (int k = 0; k < MAX_BYTES; k++)
              if (lane_en[k]) buf_q[k*8 +: 8] <= rd_shift[k*8 +: 8];
          end
          cnt_q <= cnt_q + 2'd1;
          if (last_part) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module line_split_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 16,
  parameter int MAX_BYTES  = 8,
  localparam int SIZE_W    = $clog2(MAX_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [SIZE_W-1:0] mem_size,
  input logic              mem_resp,
  input logic              done_valid
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_size));

  // R3
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_size != '0 &&
      ((mem_addr & ~OFF_MASK) == ((mem_addr + ADDR_W'(mem_size) - ADDR_W'(1)) & ~OFF_MASK)));

  // R4
  resp_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_resp |-> !mem_valid && !req_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R9
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> req_ready);
endmodule

bind line_split_unit line_split_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)
) u_chk (.*);

// File: tb/line_split_unit_tb.sv
module line_split_unit_tb;
  localparam int AW = 8, LB = 8, MB = 8, FW = 4;
  localparam int SW = $clog2(MB + 1), DW = 8 * MB;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [FW-1:0] req_flags = '0;
  logic          mem_valid, mem_write;
  logic          mem_ready = 1'b0, mem_resp = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [SW-1:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic [FW-1:0] mem_flags;
  logic          done_valid, done_split;
  logic [DW-1:0] done_rdata;

  line_split_unit #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_BYTES(MB), .FLAG_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_wdata(req_wdata), .req_flags(req_flags), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_write(mem_write), .mem_wdata(mem_wdata), .mem_flags(mem_flags),
    .mem_resp(mem_resp), .mem_rdata(mem_rdata), .done_valid(done_valid),
    .done_rdata(done_rdata), .done_split(done_split));

  int n_chk = 0, n_bad = 0, cyc = 0, mode = 0;
  int t_addr, t_size, t_bnd, t_s0;
  bit t_wr, t_cross, finished = 1'b0;
  logic [DW-1:0] t_wdata;
  logic [FW-1:0] t_flags;
  int parts_seen = 0, resps = 0, last_resp_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 7 + 3) ^ 8'hA5);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // downstream responder
  initial begin
    bit pend = 1'b0, rdy, was_pend;
    int pdly = 0, paddr = 0, psz = 0, off, d;
    forever begin
      @(negedge clk);
      mem_resp = 1'b0;
      was_pend = pend;
      if (pend) begin
        if (pdly == 0) begin
          mem_resp = 1'b1;
          for (int i = 0; i < MB; i++)
            mem_rdata[i*8 +: 8] = (i < psz) ? mem_byte(paddr + i) : 8'hEE;
          pend = 1'b0;
          resps++;
          last_resp_cyc = cyc;
        end else pdly--;
      end
      case (mode)
        0: begin rdy = 1'b1; d = 0; end
        1: begin rdy = (cyc % 3) == 0; d = 1; end
        2: begin rdy = (cyc % 2) == 1; d = 2; end
        default: begin rdy = 1'b1; d = cyc % 3; end
      endcase
      mem_ready = rdy;
      if (mem_valid && was_pend)
        chk(1'b0, "R4 part raised before response", parts_seen, 0);
      if (mem_valid && rdy) begin
        if (parts_seen >= (t_cross ? 2 : 1))
          chk(1'b0, "R5 extra part", parts_seen + 1, t_cross ? 2 : 1);
        else if (parts_seen == 0) begin
          chk(mem_addr == AW'(t_addr), t_cross ? "R3 first addr" : "R2 single addr", mem_addr, t_addr);
          chk(mem_size == SW'(t_s0), t_cross ? "R3 first size" : "R2 single size", mem_size, t_s0);
        end else begin
          chk(mem_addr == AW'(t_bnd), "R4 second addr", mem_addr, t_bnd);
          chk(mem_size == SW'(t_size - t_s0), "R4 second size", mem_size, t_size - t_s0);
        end
        chk(mem_write == t_wr && mem_flags == t_flags, "R6 write/flags",
            {mem_write, mem_flags}, {t_wr, t_flags});
        off = (parts_seen == 0) ? 0 : t_s0;
        if (t_wr)
          for (int i = 0; i < int'(mem_size); i++)
            chk(mem_wdata[i*8 +: 8] == t_wdata[(off+i)*8 +: 8], "R6 store slice",
                mem_wdata[i*8 +: 8], t_wdata[(off+i)*8 +: 8]);
        parts_seen++;
        pend = 1'b1;
        paddr = int'(mem_addr);
        psz = int'(mem_size);
        pdly = d;
      end
    end
  end

  initial begin
    int w;
    logic [DW-1:0] exp_rd;
    #1;
    chk(req_ready && !mem_valid && !done_valid, "R1 reset outputs",
        {req_ready, mem_valid, done_valid}, 3'b100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_valid && !done_valid, "R1 after reset",
        {req_ready, mem_valid, done_valid}, 3'b100);
    for (int wr = 0; wr < 2; wr++)
      for (int a = 0; a < 4 * LB; a++)
        for (int s = 1; s <= MB; s++) begin
          mode = (a + s + wr) % 4;
          t_addr = a; t_size = s; t_wr = wr[0];
          t_bnd = (a + s - 1) & ~(LB - 1);
          t_cross = t_bnd > a;
          t_s0 = t_cross ? t_bnd - a : s;
          t_flags = FW'(a + s);
          for (int i = 0; i < MB; i++) t_wdata[i*8 +: 8] = 8'(a * 13 + i * 29 + s);
          parts_seen = 0; resps = 0;
          chk(req_ready, "R9 ready at issue", req_ready, 1);
          req_valid = 1'b1; req_addr = AW'(a); req_size = SW'(s);
          req_write = wr[0]; req_wdata = t_wdata; req_flags = t_flags;
          @(negedge clk);
          req_valid = 1'b0;
          chk(!req_ready, "R9 busy", req_ready, 0);
          w = 0;
          while (!done_valid && w < 200) begin @(negedge clk); w++; end
          if (!done_valid) begin
            chk(1'b0, "R8 no completion", 0, 1);
            continue;
          end
          chk(resps == (t_cross ? 2 : 1) && parts_seen == resps, "R5 part count",
              resps, t_cross ? 2 : 1);
          chk(cyc == last_resp_cyc + 1, "R8 pulse timing", cyc, last_resp_cyc + 1);
          chk(done_split == t_cross, "R8 split flag", done_split, t_cross);
          for (int i = 0; i < MB; i++)
            exp_rd[i*8 +: 8] = (!t_wr && i < s) ? mem_byte(a + i) : 8'h00;
          chk(done_rdata == exp_rd, "R7 merged data", done_rdata, exp_rd);
        end
    @(negedge clk);
    chk(!done_valid && req_ready, "R8 single pulse", done_valid, 0);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end
endmodule